// File: doc/BRIEF.md
# Registered Input Port Multiplexer

This block is the read side of the peripheral bus for a small 8-bit soft processor. The processor reads a peripheral with a two-cycle input access. During that access it drives an 8-bit port address for both cycles. It raises a read strobe in the second cycle only. It latches the 8-bit read-data bus at the rising edge that ends the second cycle. The block decodes the address and selects one source: the synchronised device pins, a status byte for a small receive FIFO, the FIFO head, or a free-running tick counter. It registers the selected byte once, so the processor sees it throughout the second cycle.

The FIFO is filled through a separate write interface (valid plus data). It is drained by the processor's strobed reads of the FIFO data address. Each such read removes exactly one entry. A read of an empty FIFO has no effect on it. Address map: 0x00 pins, 0x01 FIFO status, 0x02 FIFO head, 0x03 tick counter. Every other address reads as zero.

Top module: `inport_mux`

## Requirements
- R1: While rst_ni is low, in_port_o is 0x00 and the FIFO is emptied. The first status read after reset returns 0x01.
- R2: in_port_o is registered once. Its value in a cycle is the data selected by port_id_i in the previous cycle, so it is valid during the strobe cycle of every access.
- R3: Address 0x00 returns pins_i through a two-flop synchroniser. A pin change made just before an access is not yet visible to that access, and it is visible to the next one.
- R4: Address 0x01 returns the status byte. Bit 0 is FIFO empty, bit 1 is FIFO full, and bits 7:2 are zero.
- R5: Address 0x02 returns the oldest FIFO entry, or 0x00 when the FIFO is empty.
- R6: Address 0x03 returns an 8-bit counter that increments on every clock and wraps. Two reads three cycles apart differ by 3.
- R7: Any address above 0x03 returns 0x00.
- R8: A pop happens only when read_strobe_i is high, port_id_i is 0x02 and the FIFO is not empty. Each such access removes exactly one entry, and entries leave in the order they were written.
- R9: A strobed read of 0x02 while the FIFO is empty returns 0x00 and leaves the FIFO empty. A later write followed by a read returns the written byte.
- R10: The FIFO holds 16 bytes. A write while it is full is dropped and does not disturb the stored entries.
- R11: A strobe with any address other than 0x02 removes no FIFO entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_id_i | input | 8 | Port address from the processor |
| read_strobe_i | input | 1 | High in the second cycle of an input access |
| pins_i | input | 8 | Asynchronous device pin inputs |
| wr_valid_i | input | 1 | FIFO write request |
| wr_data_i | input | 8 | FIFO write data |
| in_port_o | output | 8 | Registered read data to the processor |

## Verification
A wrong FIFO pointer or count shows up at the ports on the next access. The status byte reports the wrong empty or full flag, or the head read returns an out-of-order or stale byte. A pop missed or doubled on a strobe therefore appears within one access. A mux register that follows the address with the wrong latency returns another source's data in the strobe cycle itself. A missing synchroniser stage exposes a pin change one access too early.

// File: rtl/inport_pkg.sv
package inport_pkg;
  localparam int unsigned DW = 8;
  localparam logic [7:0] ADDR_PINS   = 8'h00;
  localparam logic [7:0] ADDR_STATUS = 8'h01;
  localparam logic [7:0] ADDR_HEAD   = 8'h02;
  localparam logic [7:0] ADDR_TICK   = 8'h03;
endpackage

// File: rtl/inport_sync.sv
module inport_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/inport_fifo.sv
module inport_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [AW:0]   count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/inport_mux.sv
module inport_mux
  import inport_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    port_id_i,
  input  logic          read_strobe_i,
  input  logic [DW-1:0] pins_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] in_port_o
);
  logic [DW-1:0] pins_sync, fifo_head, rd_data, mux_q, tick_q;
  logic          fifo_empty, fifo_full, fifo_pop;
  logic [CW-1:0] fifo_count;

  inport_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  // pop only in the strobe cycle of a head access
  assign fifo_pop = read_strobe_i && (port_id_i == ADDR_HEAD) && !fifo_empty;

  inport_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wr_valid_i),
    .wdata_i(wr_data_i),
    .pop_i  (fifo_pop),
    .rdata_o(fifo_head),
    .empty_o(fifo_empty),
    .full_o (fifo_full),
    .count_o(fifo_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + 1'b1;
  end

  always_comb begin
    unique case (port_id_i)
      ADDR_PINS:   rd_data = pins_sync;
      ADDR_STATUS: rd_data = {{(DW-2){1'b0}}, fifo_full, fifo_empty};
      ADDR_HEAD:   rd_data = fifo_empty ? '0 : fifo_head;
      ADDR_TICK:   rd_data = tick_q;
      default:     rd_data = '0;
    endcase
  end

  // address holds two cycles, so one register stage is free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mux_q <= '0;
    else         mux_q <= rd_data;
  end

  assign in_port_o = mux_q;
endmodule

// File: rtl/inport_mux_chk.sv
module inport_mux_chk #(
  parameter int unsigned CW    = 5,
  parameter int unsigned DEPTH = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    port_id_i,
  input logic          read_strobe_i,
  input logic          wr_valid_i,
  input logic [7:0]    in_port_o,
  input logic [7:0]    tick_q,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (in_port_o == 8'h00); // R1
  end

  AST_STATUS_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(port_id_i) == 8'h01 |-> in_port_o == {6'b0, $past(fifo_full), $past(fifo_empty)}); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(port_id_i) > 8'h03 |-> in_port_o == 8'h00); // R7
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> tick_q == $past(tick_q) + 8'd1); // R6
  AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_strobe_i && port_id_i == 8'h02 && !fifo_empty && !wr_valid_i
    |=> fifo_count == $past(fifo_count) - 1'b1); // R8
  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_strobe_i && port_id_i == 8'h02 && fifo_empty && !wr_valid_i |=> fifo_empty); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count <= CW'(DEPTH)); // R10
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full && !(read_strobe_i && port_id_i == 8'h02) |=> fifo_full); // R10
  AST_OTHER_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_strobe_i && port_id_i != 8'h02 && !wr_valid_i |=> $stable(fifo_count)); // R11
endmodule

bind inport_mux inport_mux_chk #(.CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .port_id_i    (port_id_i),
  .read_strobe_i(read_strobe_i),
  .wr_valid_i   (wr_valid_i),
  .in_port_o    (in_port_o),
  .tick_q       (tick_q),
  .fifo_empty   (fifo_empty),
  .fifo_full    (fifo_full),
  .fifo_count   (fifo_count)
);

// File: tb/sim_inport_mux.sv
`timescale 1ns/1ps
module sim_inport_mux;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] port_id_i = 8'hFE;
  logic       read_strobe_i = 1'b0;
  logic [7:0] pins_i = 8'h00;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] in_port_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  inport_mux u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .port_id_i    (port_id_i),
    .read_strobe_i(read_strobe_i),
    .pins_i       (pins_i),
    .wr_valid_i   (wr_valid_i),
    .wr_data_i    (wr_data_i),
    .in_port_o    (in_port_o)
  );

  // {address, expected}; pins = 0xA5, FIFO empty
  localparam logic [15:0] VEC [9] = '{
    16'h00A5, 16'h0101, 16'h0200, 16'h0400, 16'h8000,
    16'hFF00, 16'h0101, 16'h7F00, 16'h00A5
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // two-cycle input access; data taken in the strobe cycle
  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk_i); port_id_i = a; read_strobe_i = 1'b0;
    @(negedge clk_i); read_strobe_i = 1'b1; v = in_port_o;
    @(negedge clk_i); read_strobe_i = 1'b0; port_id_i = 8'hFE;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk_i); wr_valid_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_valid_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..all actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, t1, t2;
    pins_i = 8'hA5;
    repeat (3) @(negedge clk_i);
    chk("R1 reset output", in_port_o, 8'h00);
    rst_ni = 1'b1;
    rd(8'h01, v); chk("R1 status after reset", v, 8'h01);

    for (int i = 0; i < 9; i++) begin
      rd(VEC[i][15:8], v);
      chk($sformatf("R2/R3/R4/R5/R7 vec %0d", i), v, VEC[i][7:0]);
    end

    // R3: pin change not seen by the immediately following access
    @(negedge clk_i); pins_i = 8'h3C;
    rd(8'h00, v); chk("R3 pins sync delay", v, 8'hA5);
    rd(8'h00, v); chk("R3 pins after sync", v, 8'h3C);

    // R6: reads three cycles apart
    rd(8'h03, t1); rd(8'h03, t2);
    chk("R6 tick step", t2 - t1, 8'd3);

    // R9: empty read
    rd(8'h02, v); chk("R9 empty head", v, 8'h00);
    rd(8'h01, v); chk("R9 still empty", v, 8'h01);

    // R10: fill past depth
    for (int i = 0; i < 17; i++) push(8'h10 + 8'(i));
    rd(8'h01, v); chk("R10 full status", v, 8'h02);
    rd(8'h01, v); chk("R11 status strobe no pop", v, 8'h02);
    for (int i = 0; i < 16; i++) begin
      rd(8'h02, v); chk($sformatf("R8 pop order %0d", i), v, 8'h10 + 8'(i));
    end
    rd(8'h01, v); chk("R10 drained after 16", v, 8'h01);
    rd(8'h02, v); chk("R9 empty after drain", v, 8'h00);
    push(8'h77);
    rd(8'h02, v); chk("R9 pointers intact", v, 8'h77);

    // R11: strobes on other addresses leave entries
    push(8'h55); push(8'h66);
    rd(8'h03, v); rd(8'h00, v); rd(8'hC3, v);
    rd(8'h01, v); chk("R4 status non-empty", v, 8'h00);
    rd(8'h02, v); chk("R11 first kept", v, 8'h55);
    rd(8'h02, v); chk("R8 one pop each", v, 8'h66);
    rd(8'h01, v); chk("R8 empty again", v, 8'h01);

    // R1: reset mid-stream clears FIFO
    push(8'h99);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); chk("R1 reset output mid", in_port_o, 8'h00);
    rst_ni = 1'b1;
    rd(8'h01, v); chk("R1 FIFO cleared", v, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule